// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block sits at the data-return end of a synchronous burst SRAM. Each clock edge it samples the command that the controller presents: a chip-select plus the global-write and byte-write strobes. It classifies that command as idle, read or write. For reads it returns the array word the controller supplies in the following cycle. It drives that word onto the data output and raises one output-enable per byte lane.

A static mode input selects between two return paths. The flow-through path passes the array word straight to the output. The registered path delays it through an output register, which costs one cycle. A deselect travels down the same valid pipeline as a read. In registered mode the data of the last read therefore stays on the bus for one extra cycle before the drivers turn off.

A write flushes any read that is still pending, so no lane drives while write data is on the bus. An active-low output-enable gates the drivers combinationally and has no effect on the pipeline.

Top module: `srout_read_stage`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every bit of `dq_oe` is 0 and `dq_out` is all zeros.
- R2: With `pipe_mode`=0 (flow-through), a read sampled at an edge drives that read's array word during the very next cycle. Back-to-back reads give one new word per cycle.
- R3: With `pipe_mode`=1 (registered), a read sampled at edge N drives its word during the cycle after edge N+1, one cycle later than flow-through. Back-to-back reads still give one word per cycle.
- R4: In registered mode, a deselect (`chip_sel`=0) sampled right after a read keeps the last word driven for one more cycle. The drivers turn off only after the second edge following the deselect. In flow-through mode the drivers turn off after the first edge.
- R5: A sampled write leaves every lane undriven in the cycle after that edge, in both modes. A registered read still pending when the write is sampled is discarded.
- R6: A selected command is a write when `gw_n`=0, or when `bw_n`=0 and at least one bit of `be_n` is 0. Any other selected command is a read, and a read enables every lane whatever `be_n` holds.
- R7: `oe_n`=1 turns every lane off within the same cycle without disturbing the pipeline. `oe_n`=0 turns lanes on only while read data is pending; when no read is pending it turns nothing on.
- R8: All bits of `dq_oe` are always equal. While a lane is off, its slice of `dq_out` is zero.
- R9: A change of `pipe_mode` made while the device is deselected governs the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through |
| chip_sel | input | 1 | Device selected this cycle (enables already combined) |
| gw_n | input | 1 | Global write strobe, active low |
| bw_n | input | 1 | Byte-write qualifier, active low |
| be_n | input | LANES (4) | Per-lane byte-write enables, active low |
| oe_n | input | 1 | Output enable, active low, acts combinationally |
| arr_rdata | input | LANES*LANE_W (36) | Array word for the read sampled at the previous edge |
| dq_out | output | LANES*LANE_W (36) | Read data, zero in lanes that are off |
| dq_oe | output | LANES (4) | Per-lane drive enable |

## Verification
The hardest case is a read still waiting in the output register when the next command arrives. Only the registered mode creates this state, and only for one cycle. The bench creates it with a read immediately followed by a deselect, and again with a read immediately followed by a write. The first case must extend the drive window; the second must cut it. Two further checks toggle `oe_n` in the middle of a cycle, between edges: once while data is pending and once while idle. These separate the combinational gate from the registered valid flag.

// File: rtl/srout_pkg.sv
package srout_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } srout_cmd_e;

  // Write when the global strobe is active, or when the byte qualifier is
  // active together with at least one lane enable.
  function automatic srout_cmd_e srout_classify(input logic sel,
                                                input logic gw_n,
                                                input logic bw_n,
                                                input logic any_lane);
    if (!sel) return CMD_IDLE;
    if (!gw_n || (!bw_n && any_lane)) return CMD_WRITE;
    return CMD_READ;
  endfunction

  // Select the output-side valid flag for the active mode.
  function automatic logic srout_pick_valid(input logic pipe,
                                            input logic v_early,
                                            input logic v_late);
    return pipe ? v_late : v_early;
  endfunction

endpackage

// File: rtl/srout_cmd_decode.sv
module srout_cmd_decode
  import srout_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             chip_sel,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] be_n,
  output logic             rd_now,
  output logic             wr_now
);

  srout_cmd_e cmd;
  logic       any_lane;

  always_comb begin
    any_lane = ~&be_n;
    cmd      = srout_classify(chip_sel, gw_n, bw_n, any_lane);
    rd_now   = (cmd == CMD_READ);
    wr_now   = (cmd == CMD_WRITE);
  end

endmodule

// File: rtl/srout_valid_pipe.sv
module srout_valid_pipe
  import srout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pipe_mode,
  input  logic oe_n,
  input  logic rd_now,
  input  logic wr_now,
  output logic cap_en,
  output logic drive_en
);

  logic v_early;
  logic v_late;
  logic data_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_early <= 1'b0;
      v_late  <= 1'b0;
    end else begin
      v_early <= rd_now;
      // A deselect moves through like a read (dual-cycle turn-off); a write
      // discards whatever is waiting in the output stage.
      v_late  <= wr_now ? 1'b0 : v_early;
    end
  end

  always_comb begin
    cap_en       = v_early;
    data_pending = srout_pick_valid(pipe_mode, v_early, v_late);
    drive_en     = data_pending & ~oe_n;
  end

  a_r2_read_marks: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> v_early);

  a_r4_dual_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (v_early && !rd_now && !wr_now) |=> v_late);

  a_r5_write_flush: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> (!v_early && !v_late));

endmodule

// File: rtl/srout_data_path.sv
module srout_data_path #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             cap_en,
  input  logic             drive_en,
  input  logic [DW-1:0]    arr_rdata,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] dq_oe
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] lane_src;

    always_ff @(posedge clk) begin
      if (!rst_n)      lane_q <= '0;
      else if (cap_en) lane_q <= arr_rdata[g*LANE_W +: LANE_W];
    end

    always_comb begin
      lane_src = pipe_mode ? lane_q : arr_rdata[g*LANE_W +: LANE_W];
      dq_out[g*LANE_W +: LANE_W] = drive_en ? lane_src : '0;
      dq_oe[g] = drive_en;
    end

    a_r8_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[g] |-> (dq_out[g*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: rtl/srout_read_stage.sv
module srout_read_stage #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             chip_sel,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] be_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    arr_rdata,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] dq_oe
);

  logic rd_now;
  logic wr_now;
  logic cap_en;
  logic drive_en;

  srout_cmd_decode #(.LANES(LANES)) u_dec (
    .chip_sel (chip_sel),
    .gw_n     (gw_n),
    .bw_n     (bw_n),
    .be_n     (be_n),
    .rd_now   (rd_now),
    .wr_now   (wr_now)
  );

  srout_valid_pipe u_vld (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .rd_now    (rd_now),
    .wr_now    (wr_now),
    .cap_en    (cap_en),
    .drive_en  (drive_en)
  );

  srout_data_path #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .cap_en    (cap_en),
    .drive_en  (drive_en),
    .arr_rdata (arr_rdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  a_r7_oe_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dq_oe == '0));

  a_r8_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == '1));

  a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_now && wr_now));

endmodule

// File: tb/tb_srout_read_stage.sv
module tb_srout_read_stage;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pipe_mode;
  logic             chip_sel;
  logic             gw_n;
  logic             bw_n;
  logic [LANES-1:0] be_n;
  logic             oe_n;
  logic [DW-1:0]    arr_rdata;
  logic [DW-1:0]    dq_out;
  logic [LANES-1:0] dq_oe;
  logic [3:0]       addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  srout_read_stage #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .chip_sel(chip_sel),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n), .oe_n(oe_n),
    .arr_rdata(arr_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] word_at(input logic [3:0] a);
    return 36'h93C5A0F1E ^ (36'(a) * 36'h013579BDF);
  endfunction

  // Array model: the addressed word appears in the cycle after each edge.
  always @(posedge clk) arr_rdata <= word_at(addr);

  task automatic chk(input string tag, input logic on, input logic [DW-1:0] ed);
    logic [LANES-1:0] eo;
    eo = on ? '1 : '0;
    checks++;
    if (dq_oe !== eo || dq_out !== ed) begin
      errors++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", tag, dq_oe, dq_out, eo, ed);
    end
  endtask

  // Present a command at the current negedge, then move to the next negedge.
  task automatic cyc(input logic sel, input logic g, input logic b,
                     input logic [LANES-1:0] e, input logic [3:0] a);
    chip_sel = sel; gw_n = g; bw_n = b; be_n = e; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a);  cyc(1'b1, 1'b1, 1'b1, 4'hF, a); endtask
  task automatic idle();                   cyc(1'b0, 1'b1, 1'b1, 4'hF, 4'd0); endtask

  task automatic t_reset();
    rst_n = 1'b0; pipe_mode = 1'b1; oe_n = 1'b0;
    chip_sel = 1'b0; gw_n = 1'b1; bw_n = 1'b1; be_n = '1; addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset held", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 1'b0, '0);
  endtask

  task automatic t_pipe_burst();
    pipe_mode = 1'b1;
    idle();
    rd(4'd5);          chk("R3 first beat not yet", 1'b0, '0);
    rd(4'd6);          chk("R3 beat0", 1'b1, word_at(4'd5));
    rd(4'd7);          chk("R3 beat1", 1'b1, word_at(4'd6));
    rd(4'd8);          chk("R3 beat2", 1'b1, word_at(4'd7));
    idle();            chk("R4 dual deselect holds last beat", 1'b1, word_at(4'd8));
    idle();            chk("R4 off after second edge", 1'b0, '0);
    idle();            chk("R8 quiet lanes zero", 1'b0, '0);
  endtask

  task automatic t_ft_burst();
    pipe_mode = 1'b0;  // changed while deselected
    idle();
    rd(4'd2);          chk("R9 R2 beat0 next cycle", 1'b1, word_at(4'd2));
    rd(4'd3);          chk("R2 beat1", 1'b1, word_at(4'd3));
    rd(4'd4);          chk("R2 beat2", 1'b1, word_at(4'd4));
    rd(4'd1);          chk("R2 beat3", 1'b1, word_at(4'd1));
    idle();            chk("R4 flow-through off after one edge", 1'b0, '0);
  endtask

  task automatic t_write_flush();
    pipe_mode = 1'b1; idle();
    rd(4'd9);                          chk("R5 pipe read pending", 1'b0, '0);
    cyc(1'b1, 1'b0, 1'b1, 4'hF, 4'd10); chk("R5 pending read discarded", 1'b0, '0);
    idle();                            chk("R5 still off", 1'b0, '0);
    pipe_mode = 1'b0; idle();
    rd(4'd11);                         chk("R5 ft read", 1'b1, word_at(4'd11));
    cyc(1'b1, 1'b1, 1'b0, 4'hE, 4'd12); chk("R5 ft byte write off", 1'b0, '0);
    idle();
  endtask

  task automatic t_byte_class();
    pipe_mode = 1'b0; idle();
    cyc(1'b1, 1'b1, 1'b0, 4'hF, 4'd12); chk("R6 bw_n low no lanes = read", 1'b1, word_at(4'd12));
    cyc(1'b1, 1'b0, 1'b1, 4'hF, 4'd13); chk("R6 gw_n low = write", 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b1, 4'h0, 4'd14); chk("R6 lane enables ignored on read", 1'b1, word_at(4'd14));
    idle();
  endtask

  task automatic t_oe_async();
    pipe_mode = 1'b0; idle();
    rd(4'd3);          chk("R7 baseline on", 1'b1, word_at(4'd3));
    #1 oe_n = 1'b1;
    #1 chk("R7 oe_n high mid-cycle", 1'b0, '0);
    oe_n = 1'b0;
    #1 chk("R7 oe_n low restores", 1'b1, word_at(4'd3));
    idle();            chk("R7 oe_n low no pending read", 1'b0, '0);
    oe_n = 1'b1;
    rd(4'd7);          chk("R7 read masked", 1'b0, '0);
    oe_n = 1'b0;
    #1 chk("R7 pipeline undisturbed", 1'b1, word_at(4'd7));
    idle();
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pipe_burst();
    t_ft_burst();
    t_write_flush();
    t_byte_class();
    t_oe_async();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule